// File: doc/BRIEF.md
# Least-Shared-First Victim Selector

This block picks the way to evict from one set of a cache bank that several processors share. Each way holds a short shift register of the IDs of the processors that last touched it. It also holds an age counter that ranks the ways of the set from most to least recently used. Every hit or fill to a way pushes the requester's ID into that way's history and makes the way the most recent.

When processor *i* asks for a victim, the block first takes an empty way. If there is none, it looks for a way whose whole history holds only *i*. Such a line is in practice private to *i*, so removing it hurts no other processor. If none qualifies, the block falls back to the plain least-recently-used way. All three rules are checked in a single combinational pass over the set. The chosen index is registered and presented with a one-cycle strobe.

Both inputs are valid-only streams with no back-pressure: the block takes an access and a victim request in every cycle that asserts them, so it has no ready pin. The result carries no ready either. A consumer must capture `vic_way` in the cycle `vic_valid` is high.

Top module: `lsf_victim_sel`

## Requirements
- R1: After reset `vic_valid` is 0, every way is empty, and every history and age is cleared.
- R2: A request in cycle t gives `vic_valid` = 1 with `vic_way` in cycle t+1 only. `vic_valid` is 0 in every cycle that does not follow a request.
- R3: While any way is empty, the victim is the lowest-indexed empty way. Way indices are binary, 0 to 7.
- R4: A fill (`acc_fill` = 1) marks the way valid, sets every history cell to the filler's 3-bit binary ID, and makes the way most recently used.
- R5: A hit by processor j shifts the way's history by one cell, with j at the head and the oldest cell dropped. The depth is 4 cells, so four hits by one processor clear all earlier IDs.
- R6: When the set is full, a way whose 4 history cells all equal the requester's ID is chosen ahead of a less recently used way that does not qualify.
- R7: When several ways qualify, the least recently used of them is chosen.
- R8: When no way qualifies, the least recently used valid way is chosen.
- R9: Each accepted access makes its way the most recent. Every valid way that was more recent than it ages by one, and the ages of a full set stay a permutation of 0 to 7.
- R10: A non-fill access to an empty way is ignored: the way stays empty and no age changes.
- R11: A request that arrives in the same cycle as an access is answered from the state before that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access (hit or fill) is presented |
| acc_way | input | 3 | Way being accessed |
| acc_id | input | 3 | Processor ID of the accessor |
| acc_fill | input | 1 | 1 = fill of a new line, 0 = hit |
| vreq_valid | input | 1 | Victim request presented |
| vreq_id | input | 3 | Processor ID asking for a victim |
| vic_valid | output | 1 | One-cycle strobe: `vic_way` holds a result |
| vic_way | output | 3 | Chosen victim way |

## Verification
A victim result is due exactly one clock after its request. An access affects a request issued in the cycle after it, but not one issued in the same cycle. The bench drives every input on the falling edge. It samples `vic_valid` and `vic_way` on the next falling edge, which falls half a cycle after the capturing rising edge, and checks on the falling edge after that that the strobe has dropped. Expected victims come from hand-traced age and history sequences, chosen so that each rule (empty way, private match, LRU tie-break, fallback) gives a different answer from the others.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  // Which rule produced the victim
  typedef enum logic [1:0] {
    SRC_EMPTY   = 2'd0,
    SRC_PRIVATE = 2'd1,
    SRC_LRU     = 2'd2
  } pick_src_e;
endpackage

// File: rtl/lsf_way_state.sv
module lsf_way_state #(
  parameter int HIST  = 4,
  parameter int ID_W  = 3,
  parameter int AGE_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel,      // accepted access targets this way
  input  logic                       any_acc,  // accepted access to some way
  input  logic                       fill,
  input  logic [ID_W-1:0]            id,
  input  logic [AGE_W-1:0]           ref_age,  // age the accessed way had
  output logic                       vld,
  output logic [HIST-1:0][ID_W-1:0]  hist,
  output logic [AGE_W-1:0]           age
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      hist <= '0;
      age  <= '0;
    end else begin
      if (sel && fill) vld <= 1'b1;

      if (sel && fill)  hist <= {HIST{id}};
      else if (sel)     hist <= {hist[HIST-2:0], id};

      if (sel)
        age <= '0;
      else if (any_acc && vld && (age < ref_age))
        age <= age + 1'b1;
    end
  end

endmodule

// File: rtl/lsf_pick.sv
module lsf_pick
  import lsf_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int HIST  = 4,
  parameter int ID_W  = 3,
  parameter int AGE_W = 3,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]                      way_vld,
  input  logic [WAYS-1:0][HIST-1:0][ID_W-1:0]  way_hist,
  input  logic [WAYS-1:0][AGE_W-1:0]           way_age,
  input  logic [ID_W-1:0]                      req_id,
  output logic [WAY_W-1:0]                     pick_way
);

  logic [WAYS-1:0]  qual;
  logic [WAYS-1:0]  cand;
  logic [WAY_W-1:0] empty_idx;
  logic [WAY_W-1:0] oldest_idx;
  logic [AGE_W-1:0] oldest_age;
  logic             have;
  pick_src_e        src;

  // Private-use test: every history cell XOR requester must be zero
  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_qual
      assign qual[g] = way_vld[g] && ((way_hist[g] ^ {HIST{req_id}}) == '0);
    end
  endgenerate

  always_comb begin
    empty_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!way_vld[w]) empty_idx = WAY_W'(w);
  end

  always_comb begin
    if (!(&way_vld))   src = SRC_EMPTY;
    else if (|qual)    src = SRC_PRIVATE;
    else               src = SRC_LRU;
    cand = (src == SRC_PRIVATE) ? qual : way_vld;
  end

  always_comb begin
    have       = 1'b0;
    oldest_idx = '0;
    oldest_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (cand[w] && (!have || (way_age[w] > oldest_age))) begin
        have       = 1'b1;
        oldest_idx = WAY_W'(w);
        oldest_age = way_age[w];
      end
    end
  end

  assign pick_way = (src == SRC_EMPTY) ? empty_idx : oldest_idx;

endmodule

// File: rtl/lsf_victim_sel.sv
module lsf_victim_sel #(
  parameter int WAYS    = 8,
  parameter int NUM_CPU = 8,
  parameter int HIST    = 4,
  localparam int ID_W   = $clog2(NUM_CPU),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int AGE_W  = WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [ID_W-1:0]  acc_id,
  input  logic             acc_fill,
  input  logic             vreq_valid,
  input  logic [ID_W-1:0]  vreq_id,
  output logic             vic_valid,
  output logic [WAY_W-1:0] vic_way
);

  logic [WAYS-1:0]                      way_vld;
  logic [WAYS-1:0][HIST-1:0][ID_W-1:0]  way_hist;
  logic [WAYS-1:0][AGE_W-1:0]           way_age;
  logic                                 acc_ok;
  logic [AGE_W-1:0]                     ref_age;
  logic [WAY_W-1:0]                     pick_way;

  // A hit on an empty way is dropped; a fill always lands
  assign acc_ok  = acc_valid && (acc_fill || way_vld[acc_way]);
  assign ref_age = way_vld[acc_way] ? way_age[acc_way] : AGE_W'(WAYS - 1);

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_way
      lsf_way_state #(.HIST(HIST), .ID_W(ID_W), .AGE_W(AGE_W)) way_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (acc_ok && (acc_way == WAY_W'(g))),
        .any_acc (acc_ok),
        .fill    (acc_fill),
        .id      (acc_id),
        .ref_age (ref_age),
        .vld     (way_vld[g]),
        .hist    (way_hist[g]),
        .age     (way_age[g])
      );
    end
  endgenerate

  lsf_pick #(.WAYS(WAYS), .HIST(HIST), .ID_W(ID_W), .AGE_W(AGE_W)) pick_i (
    .way_vld  (way_vld),
    .way_hist (way_hist),
    .way_age  (way_age),
    .req_id   (vreq_id),
    .pick_way (pick_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_valid <= 1'b0;
      vic_way   <= '0;
    end else begin
      vic_valid <= vreq_valid;
      if (vreq_valid) vic_way <= pick_way;
    end
  end

endmodule

// File: rtl/lsf_victim_sel_chk.sv
module lsf_victim_sel_chk #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3,
  parameter int AGE_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       acc_valid,
  input logic [WAY_W-1:0]           acc_way,
  input logic                       acc_fill,
  input logic                       vreq_valid,
  input logic                       vic_valid,
  input logic [WAY_W-1:0]           vic_way,
  input logic [WAYS-1:0]            way_vld,
  input logic [WAYS-1:0][AGE_W-1:0] way_age
);

  logic [WAYS-1:0] prev_vld;
  logic [WAYS-1:0] age_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_vld <= '0;
    else        prev_vld <= way_vld;
  end

  always_comb begin
    age_seen = '0;
    for (int w = 0; w < WAYS; w++) age_seen[way_age[w]] = 1'b1;
  end

  assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vreq_valid |=> vic_valid);

  assert_no_stray_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vreq_valid |=> !vic_valid);

  assert_empty_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !(&prev_vld)) |-> !prev_vld[vic_way]);

  assert_fill_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fill) |=> way_vld[$past(acc_way)]);

  assert_mru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_fill || way_vld[acc_way])) |=> (way_age[$past(acc_way)] == '0));

  assert_age_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&way_vld) |-> (&age_seen));

endmodule

bind lsf_victim_sel lsf_victim_sel_chk #(.WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_way    (acc_way),
  .acc_fill   (acc_fill),
  .vreq_valid (vreq_valid),
  .vic_valid  (vic_valid),
  .vic_way    (vic_way),
  .way_vld    (way_vld),
  .way_age    (way_age)
);

// File: tb/lsf_victim_sel_tb_top.sv
`timescale 1ns/1ps
module lsf_victim_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [2:0] acc_way = '0;
  logic [2:0] acc_id = '0;
  logic       acc_fill = 1'b0;
  logic       vreq_valid = 1'b0;
  logic [2:0] vreq_id = '0;
  logic       vic_valid;
  logic [2:0] vic_way;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  lsf_victim_sel dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_way(acc_way), .acc_id(acc_id), .acc_fill(acc_fill),
    .vreq_valid(vreq_valid), .vreq_id(vreq_id),
    .vic_valid(vic_valid), .vic_way(vic_way)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input int way, input int id, input bit fill);
    @(negedge clk);
    acc_valid = 1'b1; acc_way = 3'(way); acc_id = 3'(id); acc_fill = fill;
    @(negedge clk);
    acc_valid = 1'b0; acc_fill = 1'b0;
  endtask

  // Request; result due one cycle later, strobe gone the cycle after
  task automatic ask(input int id, input int exp, input string req);
    @(negedge clk);
    vreq_valid = 1'b1; vreq_id = 3'(id);
    @(negedge clk);
    vreq_valid = 1'b0;
    check({req, " R2 strobe"}, int'(vic_valid), 1);
    check(req, int'(vic_way), exp);
    @(negedge clk);
    check("R2 strobe drop", int'(vic_valid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 vic_valid in reset", int'(vic_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vic_valid after reset", int'(vic_valid), 0);
    access(0, 1, 1'b0);              // R10: hit to empty way ignored
    ask(1, 0, "R10 ignored hit leaves way 0 empty");
  endtask

  task automatic t_fill_partial;
    access(0, 0, 1'b1);
    access(1, 1, 1'b1);
    access(2, 2, 1'b1);
    ask(2, 3, "R3 lowest empty way");
    access(3, 5, 1'b0);              // R10 again on way 3
    ask(5, 3, "R10 ignored hit on way 3");
  endtask

  task automatic t_fill_rest;
    for (int w = 3; w < 8; w++) access(w, w, 1'b1);
    ask(5, 5, "R4 fill history equals filler");
    ask(3, 3, "R6 private way beats older way 0");
    ask(0, 0, "R6 private way 0");
  endtask

  task automatic t_share;
    access(3, 2, 1'b0);              // way 3 history 2,3,3,3
    ask(3, 0, "R8 no private way, LRU fallback");
    ask(2, 2, "R6 way 2 still private");
    for (int k = 0; k < 3; k++) access(3, 3, 1'b0);
    ask(3, 0, "R5 three hits keep old ID in history");
    access(3, 3, 1'b0);
    ask(3, 3, "R5 fourth hit clears history");
  endtask

  task automatic t_multi;
    access(6, 1, 1'b1);              // ways 1 and 6 both private to 1
    ask(1, 1, "R7 older of two private ways");
    access(1, 1, 1'b0);
    ask(1, 6, "R7 order flips after hit");
  endtask

  task automatic t_lru;
    access(0, 4, 1'b0);              // way 0 now shared; way 2 oldest
    ask(0, 2, "R9 hit moves way 0 to MRU, R8 fallback");
    @(negedge clk);                  // simultaneous hit on way 2 and request
    acc_valid = 1'b1; acc_way = 3'd2; acc_id = 3'd5; acc_fill = 1'b0;
    vreq_valid = 1'b1; vreq_id = 3'd0;
    @(negedge clk);
    acc_valid = 1'b0; vreq_valid = 1'b0;
    check("R11 same-cycle access not seen", int'(vic_way), 2);
    ask(0, 4, "R9 ages after hit on way 2");
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    t_fill_partial;
    t_fill_rest;
    t_share;
    t_multi;
    t_lru;
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule